// File: doc/BRIEF.md
# Parallel NOR Flash Command Port

This block is a clocked model of the bus-facing command logic of a 16-bit-wide parallel NOR flash. It samples three active-low strobes (chip select, output gate, write strobe), an 18-bit word address and the incoming data word. Each input passes through a configurable register chain before the logic uses it. A write cycle is the span during which both chip select and write strobe are low. The block takes the address when that span opens and the data as it closes. A word program is accepted only after three key writes in the correct order. The block then enters a timed busy window. During that window every write is dropped, and reads return a polling status word instead of array contents.

The bidirectional data bus is split into an input word, an output word and a drive-enable flag. When the drive-enable flag is low, the pin is high impedance. A reduced storage array of 256 words, indexed by the low address bits, holds the data. Its erased value is all ones, and programming can only clear bits. The block also reports the sector and block fields of the address most recently programmed, which is the address decode that an erase controller would use.

Top module: `pfl_cmd_port`

## Requirements
- R1: A bus write exists only while chip select and write strobe are both low. Its address is the value sampled when that common low span begins. Its data is the last value sampled before either strobe rises. Write-strobe pulses while chip select is high are not writes.
- R2: A word program takes four writes in order. The first three are keys, with address bits 14:0 and data bits 7:0 compared: 0x5555/0xAA, then 0x2AAA/0x55, then 0x5555/0xA0. The fourth write carries the target address and data, and none of its bits are compared.
- R3: A write whose address or data does not match the key expected at that step sends the sequencer back to idle. The next write is then compared against the first key.
- R4: The busy window opens at the end of the fourth write and lasts PROG_CYCLES = CLK_MHZ*PROG_US clock cycles. The array word is updated when the window closes.
- R5: Every write during the busy window is ignored, including a complete key sequence with a program write.
- R6: A read during busy returns a status word. Bit 7 is the complement of bit 7 of the data being programmed. Bit 6 is 0 on the first read and inverts after each busy read. All other bits are 0.
- R7: Once the busy window has closed, reads return array contents again.
- R8: The drive-enable flag is high only while chip select and output gate are both low. While it is low, the output word is 0.
- R9: After reset every array word reads 0xFFFF. A program sets the word at index addr[7:0] to the old value AND the new data.
- R10: The sector output shows address bits 17:11 of the latest program target, and the block output shows bits 17:15. Both outputs are 0 after reset and change only when a program starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 18 | Word address |
| dq_i | input | 16 | Data word driven onto the bus by the host |
| dq_o | output | 16 | Data word driven by the block |
| dq_oe | output | 1 | Bus drive enable; 0 means high impedance |
| tgt_sector | output | 7 | Sector field of the latest program target |
| tgt_block | output | 3 | Block field of the latest program target |

## Verification
The bench moves the address and data in the middle of a write span. A design that latched the address late, or took the data early, would program the wrong word or the wrong value. It inserts a write-strobe pulse with chip select high between two key writes. A design that counted that pulse as a write would abort the unlock. It corrupts each key step in turn, and it sends a full key sequence during busy; if either were accepted, a word that should be untouched would change. It also reads just before and just after the end of the busy window, and reads polling status several times in a row. These reads catch a window of the wrong length, an inverted polling bit, and a toggle bit that does not alternate.

// File: rtl/pfl_pkg.sv
package pfl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_UNL1  = 3'd1,
      ST_UNL2  = 3'd2,
      ST_ARMED = 3'd3,
      ST_BUSY  = 3'd4
   } cmd_st_t;

   localparam int KEY_AW = 15;
   localparam int KEY_DW = 8;

   localparam logic [KEY_AW-1:0] KEY_ADDR_A = 15'h5555;
   localparam logic [KEY_AW-1:0] KEY_ADDR_B = 15'h2AAA;
   localparam logic [KEY_DW-1:0] KEY_DATA_1 = 8'hAA;
   localparam logic [KEY_DW-1:0] KEY_DATA_2 = 8'h55;
   localparam logic [KEY_DW-1:0] KEY_DATA_3 = 8'hA0;

   function automatic logic key_hit(input logic [KEY_AW-1:0] a,
                                    input logic [KEY_DW-1:0] d,
                                    input logic [KEY_AW-1:0] ea,
                                    input logic [KEY_DW-1:0] ed);
      return (a == ea) && (d == ed);
   endfunction

endpackage

// File: rtl/pfl_in_sync.sv
module pfl_in_sync #(
   parameter int            W       = 1,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   initial begin
      if (W < 1)       $error("pfl_in_sync: W must be at least 1");
      if (STAGES < 0)  $error("pfl_in_sync: STAGES must not be negative");
   end

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
            end else begin
               pipe[0] <= d;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pfl_bus_cycle.sv
module pfl_bus_cycle #(
   parameter int AW = 18,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] dq,
   output logic          wr_end,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   output logic          rd_act,
   output logic          rd_end
);

   logic wr_now, wr_q, rd_q;

   assign wr_now = !ce_n && !we_n;
   assign rd_act = !ce_n && !oe_n;
   assign wr_end = wr_q && !wr_now;
   assign rd_end = rd_q && !rd_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         rd_q    <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_q <= wr_now;
         rd_q <= rd_act;
         // address taken when the later strobe falls (span opens)
         if (wr_now && !wr_q) wr_addr <= addr;
         // data follows the bus while the span is open; frozen when it closes
         if (wr_now) wr_data <= dq;
      end
   end

endmodule

// File: rtl/pfl_cmd_fsm.sv
module pfl_cmd_fsm
   import pfl_pkg::*;
#(
   parameter int AW          = 18,
   parameter int DW          = 16,
   parameter int PROG_CYCLES = 5000,
   parameter int SECT_LSB    = 11,
   parameter int BLK_LSB     = 15
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_end,
   input  logic [AW-1:0]         wr_addr,
   input  logic [DW-1:0]         wr_data,
   input  logic                  rd_end,
   output cmd_st_t               st,
   output logic                  busy,
   output logic                  done,
   output logic [AW-1:0]         prog_addr,
   output logic [DW-1:0]         prog_data,
   output logic                  tog,
   output logic [AW-SECT_LSB-1:0] tgt_sector,
   output logic [AW-BLK_LSB-1:0]  tgt_block
);

   localparam int CNT_W = $clog2(PROG_CYCLES + 1);

   logic [CNT_W-1:0] cnt;
   logic [KEY_AW-1:0] ka;
   logic [KEY_DW-1:0] kd;

   assign ka   = wr_addr[KEY_AW-1:0];
   assign kd   = wr_data[KEY_DW-1:0];
   assign busy = (st == ST_BUSY);
   assign done = busy && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         cnt        <= '0;
         prog_addr  <= '0;
         prog_data  <= '0;
         tog        <= 1'b0;
         tgt_sector <= '0;
         tgt_block  <= '0;
      end else begin
         unique case (st)
            ST_IDLE: if (wr_end)
               st <= key_hit(ka, kd, KEY_ADDR_A, KEY_DATA_1) ? ST_UNL1 : ST_IDLE;
            ST_UNL1: if (wr_end)
               st <= key_hit(ka, kd, KEY_ADDR_B, KEY_DATA_2) ? ST_UNL2 : ST_IDLE;
            ST_UNL2: if (wr_end)
               st <= key_hit(ka, kd, KEY_ADDR_A, KEY_DATA_3) ? ST_ARMED : ST_IDLE;
            ST_ARMED: if (wr_end) begin
               st         <= ST_BUSY;
               prog_addr  <= wr_addr;
               prog_data  <= wr_data;
               cnt        <= CNT_W'(PROG_CYCLES - 1);
               tog        <= 1'b0;
               tgt_sector <= wr_addr[AW-1:SECT_LSB];
               tgt_block  <= wr_addr[AW-1:BLK_LSB];
            end
            ST_BUSY: begin
               if (cnt == '0) st <= ST_IDLE;
               else           cnt <= cnt - 1'b1;
               if (rd_end) tog <= !tog;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pfl_store.sv
module pfl_store #(
   parameter int AW    = 18,
   parameter int DW    = 16,
   parameter int DEPTH = 256
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [DW-1:0]    mem [DEPTH];
   logic [IDX_W-1:0] widx, ridx;

   assign widx  = waddr[IDX_W-1:0];
   assign ridx  = raddr[IDX_W-1:0];
   assign rdata = mem[ridx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (wr_en) begin
         mem[widx] <= mem[widx] & wdata;
      end
   end

endmodule

// File: rtl/pfl_cmd_port.sv
module pfl_cmd_port
   import pfl_pkg::*;
#(
   parameter int AW          = 18,
   parameter int DW          = 16,
   parameter int DEPTH       = 256,
   parameter int CLK_MHZ     = 125,
   parameter int PROG_US     = 40,
   parameter int SYNC_STAGES = 2,
   parameter int SECT_LSB    = 11,
   parameter int BLK_LSB     = 15
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ce_n,
   input  logic                    oe_n,
   input  logic                    we_n,
   input  logic [AW-1:0]           addr,
   input  logic [DW-1:0]           dq_i,
   output logic [DW-1:0]           dq_o,
   output logic                    dq_oe,
   output logic [AW-SECT_LSB-1:0]  tgt_sector,
   output logic [AW-BLK_LSB-1:0]   tgt_block
);

   localparam int PROG_CYCLES = CLK_MHZ * PROG_US;
   localparam int BUS_W       = AW + DW;

   initial begin
      if (AW < KEY_AW)              $error("pfl_cmd_port: AW too narrow for key addresses");
      if (DW < KEY_DW)              $error("pfl_cmd_port: DW too narrow for key data");
      if (DEPTH < 2 || DEPTH > 4096) $error("pfl_cmd_port: DEPTH out of range");
      if ((1 << $clog2(DEPTH)) != DEPTH) $error("pfl_cmd_port: DEPTH must be a power of two");
      if (PROG_CYCLES < 1)          $error("pfl_cmd_port: program time must be at least one cycle");
      if (SYNC_STAGES > 4)          $error("pfl_cmd_port: SYNC_STAGES above 4");
      if (!(SECT_LSB < BLK_LSB && BLK_LSB < AW)) $error("pfl_cmd_port: region fields misordered");
   end

   // synchronised inputs
   logic [2:0]    strb_s;
   logic [BUS_W-1:0] bus_s;
   logic          ce_s, oe_s, we_s;
   logic [AW-1:0] addr_s;
   logic [DW-1:0] dqi_s;

   pfl_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync_strb (
      .clk(clk), .rst_n(rst_n), .d({ce_n, oe_n, we_n}), .q(strb_s));

   pfl_in_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
      .clk(clk), .rst_n(rst_n), .d({addr, dq_i}), .q(bus_s));

   assign {ce_s, oe_s, we_s} = strb_s;
   assign {addr_s, dqi_s}    = bus_s;

   // bus cycle detection
   logic          wr_end, rd_act, rd_end;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;

   pfl_bus_cycle #(.AW(AW), .DW(DW)) u_cycle (
      .clk(clk), .rst_n(rst_n),
      .ce_n(ce_s), .oe_n(oe_s), .we_n(we_s),
      .addr(addr_s), .dq(dqi_s),
      .wr_end(wr_end), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_act(rd_act), .rd_end(rd_end));

   // command sequencer and busy timer
   cmd_st_t       st;
   logic          busy, done, tog;
   logic [AW-1:0] prog_addr;
   logic [DW-1:0] prog_data;

   pfl_cmd_fsm #(
      .AW(AW), .DW(DW), .PROG_CYCLES(PROG_CYCLES),
      .SECT_LSB(SECT_LSB), .BLK_LSB(BLK_LSB)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .wr_end(wr_end), .wr_addr(wr_addr), .wr_data(wr_data), .rd_end(rd_end),
      .st(st), .busy(busy), .done(done),
      .prog_addr(prog_addr), .prog_data(prog_data), .tog(tog),
      .tgt_sector(tgt_sector), .tgt_block(tgt_block));

   // storage
   logic [DW-1:0] arr_rd;

   pfl_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(done), .waddr(prog_addr), .wdata(prog_data),
      .raddr(addr_s), .rdata(arr_rd));

   // read path
   logic [DW-1:0] status_w, rd_word;

   always_comb begin
      status_w    = '0;
      status_w[7] = !prog_data[7];
      status_w[6] = tog;
   end

   assign rd_word = busy ? status_w : arr_rd;
   assign dq_oe   = rd_act;
   assign dq_o    = rd_act ? rd_word : '0;

endmodule

// File: rtl/pfl_cmd_port_chk.sv
module pfl_cmd_port_chk
   import pfl_pkg::*;
#(
   parameter int AW    = 18,
   parameter int DW    = 16,
   parameter int SEC_W = 7,
   parameter int BLK_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dq_oe,
   input logic [DW-1:0]    dq_o,
   input cmd_st_t          st,
   input logic             busy,
   input logic             done,
   input logic             wr_end,
   input logic [AW-1:0]    wr_addr,
   input logic [DW-1:0]    wr_data,
   input logic             rd_end,
   input logic             tog,
   input logic [AW-1:0]    prog_addr,
   input logic [SEC_W-1:0] tgt_sector,
   input logic [BLK_W-1:0] tgt_block
);

   // R8
   quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_oe |-> (dq_o == '0));

   // R4
   busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(wr_end) && $past(st) == ST_ARMED));

   // R5
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_end && !done) |=> (busy && $stable(prog_addr)));

   // R3
   key2_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_UNL1 && wr_end &&
       !(wr_addr[14:0] == 15'h2AAA && wr_data[7:0] == 8'h55)) |=> (st == ST_IDLE));

   // R6
   toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_end && !done) |=> (tog != $past(tog)));

   // R10
   region_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(busy) |-> ($stable(tgt_sector) && $stable(tgt_block)));

endmodule

bind pfl_cmd_port pfl_cmd_port_chk #(
   .AW(AW), .DW(DW), .SEC_W(AW - SECT_LSB), .BLK_W(AW - BLK_LSB)
) u_chk (
   .clk(clk), .rst_n(rst_n), .dq_oe(dq_oe), .dq_o(dq_o),
   .st(st), .busy(busy), .done(done),
   .wr_end(wr_end), .wr_addr(wr_addr), .wr_data(wr_data),
   .rd_end(rd_end), .tog(tog), .prog_addr(prog_addr),
   .tgt_sector(tgt_sector), .tgt_block(tgt_block));

// File: tb/pfl_cmd_port_test.sv
`timescale 1ns/1ps
module pfl_cmd_port_test;

   localparam int CLK_MHZ = 125;
   localparam int PROG_US = 2;
   localparam int PROG_CYCLES = CLK_MHZ * PROG_US;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [17:0] addr = '0;
   logic [15:0] dq_i = '0;
   logic [15:0] dq_o;
   logic        dq_oe;
   logic [6:0]  tgt_sector;
   logic [2:0]  tgt_block;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   logic [15:0] model [256];

   always #4 clk = !clk;

   pfl_cmd_port #(.CLK_MHZ(CLK_MHZ), .PROG_US(PROG_US)) uut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
      .tgt_sector(tgt_sector), .tgt_block(tgt_block));

   function automatic logic [15:0] merge(input logic [15:0] old_w, input logic [15:0] new_w);
      return old_w & new_w;
   endfunction

   function automatic logic [15:0] poll_word(input logic [15:0] d, input int nth);
      logic [15:0] s;
      s = '0;
      s[7] = !d[7];
      s[6] = nth[0];
      return s;
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [17:0] a, input logic [15:0] d);
      @(negedge clk);
      addr = a; dq_i = d; ce_n = 1'b0; we_n = 1'b0;
      repeat (4) @(negedge clk);
      we_n = 1'b1;
      repeat (2) @(negedge clk);
      ce_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic bus_read(input logic [17:0] a, output logic [15:0] d, output logic oe);
      @(negedge clk);
      addr = a; ce_n = 1'b0; oe_n = 1'b0;
      repeat (5) @(negedge clk);
      d = dq_o; oe = dq_oe;
      oe_n = 1'b1; ce_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic unlock();
      bus_write(18'h05555, 16'h00AA);
      bus_write(18'h02AAA, 16'h0055);
      bus_write(18'h05555, 16'h00A0);
   endtask

   task automatic wait_prog();
      repeat (PROG_CYCLES + 20) @(negedge clk);
   endtask

   task automatic read_expect(input string req, input logic [17:0] a);
      logic [15:0] d;
      logic oe;
      bus_read(a, d, oe);
      check(req, "array read", {16'h0, d}, {16'h0, model[a[7:0]]});
      check("R8", "drive during read", {31'h0, oe}, 32'h1);
   endtask

   task automatic program_word(input logic [17:0] a, input logic [15:0] d);
      unlock();
      bus_write(a, d);
      check("R10", "sector field", {25'h0, tgt_sector}, {25'h0, a[17:11]});
      check("R10", "block field", {29'h0, tgt_block}, {29'h0, a[17:15]});
      wait_prog();
      model[a[7:0]] = merge(model[a[7:0]], d);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL R4 watchdog: actual=hung expected=complete");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] d;
      logic oe;
      logic [17:0] a;
      logic [15:0] w;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // reset state
      check("R8", "reset drive", {31'h0, dq_oe}, 32'h0);
      check("R10", "reset sector", {25'h0, tgt_sector}, 32'h0);
      check("R10", "reset block", {29'h0, tgt_block}, 32'h0);
      read_expect("R9", 18'h00000);
      read_expect("R9", 18'h3FFFF);

      // R8: no drive unless both chip select and output gate are low
      @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
      repeat (5) @(negedge clk);
      check("R8", "oe only", {15'h0, dq_oe, dq_o}, 32'h0);
      oe_n = 1'b1; ce_n = 1'b0;
      repeat (5) @(negedge clk);
      check("R8", "ce only", {15'h0, dq_oe, dq_o}, 32'h0);
      ce_n = 1'b1;
      repeat (3) @(negedge clk);

      // R2 / R9 / R7: basic program and AND merge
      program_word(18'h2C812, 16'h5A3C);
      read_expect("R2", 18'h2C812);
      program_word(18'h2C812, 16'hF0F0);
      read_expect("R9", 18'h2C812);

      // R1: address at span start, data at span end, ce held low, we falls later
      unlock();
      @(negedge clk);
      ce_n = 1'b0; addr = 18'h3FF21; dq_i = 16'h1111;
      repeat (3) @(negedge clk);
      we_n = 1'b0; addr = 18'h0A0C4; dq_i = 16'h2222;
      repeat (3) @(negedge clk);
      addr = 18'h0A0D9; dq_i = 16'hC3E7;
      repeat (3) @(negedge clk);
      ce_n = 1'b1;
      repeat (2) @(negedge clk);
      we_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", "latched sector", {25'h0, tgt_sector}, {25'h0, 7'(18'h0A0C4 >> 11)});
      wait_prog();
      model[8'hC4] = merge(model[8'hC4], 16'hC3E7);
      read_expect("R1", 18'h0A0C4);
      read_expect("R1", 18'h0A0D9);

      // R1: write strobe pulse with chip select high is not a write
      bus_write(18'h05555, 16'h00AA);
      @(negedge clk); addr = 18'h01234; dq_i = 16'h0000; we_n = 1'b0;
      repeat (4) @(negedge clk); we_n = 1'b1;
      repeat (3) @(negedge clk);
      bus_write(18'h02AAA, 16'h0055);
      bus_write(18'h05555, 16'h00A0);
      bus_write(18'h00077, 16'h0F0F);
      wait_prog();
      model[8'h77] = merge(model[8'h77], 16'h0F0F);
      read_expect("R1", 18'h00077);

      // R6 / R4 / R7: polling reads, window length
      unlock();
      bus_write(18'h1F0E5, 16'h6A81);
      model[8'hE5] = merge(model[8'hE5], 16'h6A81);
      for (int k = 0; k < 3; k++) begin
         bus_read(18'h1F0E5, d, oe);
         check("R6", "poll word", {16'h0, d}, {16'h0, poll_word(16'h6A81, k)});
      end
      repeat (PROG_CYCLES - 70) @(negedge clk);
      bus_read(18'h1F0E5, d, oe);
      check("R4", "still busy near end", {16'h0, d}, {16'h0, poll_word(16'h6A81, 3)});
      repeat (60) @(negedge clk);
      bus_read(18'h1F0E5, d, oe);
      check("R7", "data after busy", {16'h0, d}, {16'h0, model[8'hE5]});

      // R5: full command during busy is dropped
      unlock();
      bus_write(18'h00310, 16'h7F7F);
      model[8'h10] = merge(model[8'h10], 16'h7F7F);
      unlock();
      bus_write(18'h00345, 16'h0000);
      check("R5", "sector unchanged by busy write", {25'h0, tgt_sector}, 32'h0);
      wait_prog();
      read_expect("R5", 18'h00345);
      read_expect("R5", 18'h00310);

      // R3: corrupt each key step
      for (int step = 0; step < 3; step++) begin
         bus_write(18'h05555, (step == 0) ? 16'h00AB : 16'h00AA);
         if (step >= 1) bus_write(18'h02AAA, (step == 1) ? 16'h0054 : 16'h0055);
         if (step == 2) bus_write(18'h05554, 16'h00A0);
         if (step < 2) bus_write(18'h05555, 16'h00A0);
         bus_write(18'h00099, 16'h0000);
         wait_prog();
         read_expect("R3", 18'h00099);
      end

      // constrained random mix
      for (int it = 0; it < 36; it++) begin
         int mode;
         mode = $urandom_range(0, 2);
         a = 18'($urandom);
         w = 16'($urandom);
         if (w[7:0] == 8'hAA) w[7:0] = 8'hAB;
         if (mode == 0) begin
            program_word(a, w);
            read_expect("R9", a);
         end else if (mode == 1) begin
            int bad;
            bad = $urandom_range(0, 2);
            bus_write(18'h05555, (bad == 0) ? 16'h00A9 : 16'h00AA);
            bus_write(18'h02AAA, (bad == 1) ? 16'h0075 : 16'h0055);
            bus_write(18'h05555, (bad == 2) ? 16'h00A1 : 16'h00A0);
            bus_write(a, w);
            wait_prog();
            read_expect("R3", a);
         end else begin
            read_expect("R7", a);
         end
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule